// File: doc/BRIEF.md
# Multi-Channel DC Removal Stage with Offset Hold

This block removes the DC component from six signed audio sample streams that leave a decimation filter. Each channel keeps its own running estimate of the DC offset in a leaky integrator. Every valid sample has the current estimate subtracted from it, and the result is clamped to the sample range.

The channels fall into two enable groups. Group A is channels 0 to 3 and group B is channels 4 and 5. When a group is disabled its channels stop updating the estimate. The held estimate is still subtracted, so disabling is not a bypass. This allows a one-time system offset calibration: run enabled until the estimate settles, then disable to keep it.

A mode input chooses where the group enables come from. In pin mode, group A always tracks and group B follows a dedicated pin. In register mode, both groups follow control bits.

Each channel has a two-state machine. ST_HOLD is the reset state: the estimate is kept. ST_TRACK: the estimate is updated on valid samples. The transition RESUME (ST_HOLD to ST_TRACK) is taken at a clock edge where the group enable is high. The transition FREEZE (ST_TRACK to ST_HOLD) is taken at an edge where the group enable is low.

Top module: `dcblk_top`

## Requirements
- R1: After reset, out_valid is all zero, out_data is all zero and every offset accumulator is zero, so the first valid sample of a channel comes out unchanged.
- R2: out_valid[i] is high exactly one cycle after in_valid[i] is high and low otherwise. out_data for channel i changes only in the cycle after a valid input.
- R3: While a channel is in ST_TRACK, each valid sample x updates the accumulator A (which holds the offset times 2^10) to A + floor((x*2^10 - A) / 2^10). Over a constant DC plus a zero-mean tone, the output mean goes toward zero.
- R4: The output for a valid sample is x - floor(A / 2^10), where A is the accumulator value before that sample's update.
- R5: In ST_HOLD the accumulator does not change, and the held offset is still subtracted from every valid sample.
- R6: When a held channel is enabled again, tracking continues from the held accumulator value.
- R7: The subtraction result saturates to the 24-bit two's-complement range, from -8388608 to 8388607.
- R8: With sw_mode = 0 (pin mode), channels 0 to 3 always track and channels 4 and 5 track while pin_en_b is 1. reg_en_a and reg_en_b have no effect.
- R9: With sw_mode = 1 (register mode), channels 0 to 3 track while reg_en_a is 1 and channels 4 and 5 track while reg_en_b is 1. pin_en_b has no effect.
- R10: The group enable is registered into the channel state at each clock edge. A change made in one cycle first applies to samples presented in the following cycle.
- R11: A cycle in which a channel's in_valid is low leaves that channel's accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_mode | input | 1 | 0: pin mode, 1: register mode |
| pin_en_b | input | 1 | Group B enable used in pin mode |
| reg_en_a | input | 1 | Group A enable used in register mode |
| reg_en_b | input | 1 | Group B enable used in register mode |
| in_valid | input | 6 | Per-channel sample strobe |
| in_data | input | 144 | Six 24-bit signed samples, channel i at bits [24i+23:24i] |
| out_valid | output | 6 | Per-channel output strobe |
| out_data | output | 144 | Six 24-bit signed results, packed the same way as in_data |

## Verification
The hardest condition to reach is saturation. The offset has a time constant of 1024 samples, so it must first be pulled close to full scale. Only then can an opposite full-scale input push the difference outside the 24-bit range. The bench does this by feeding full-scale DC of opposite signs to the two channel halves for several thousand samples, freezing, and then applying the opposite extreme. Between those phases, every output sample is compared with an arithmetic model of the integrator, including the one-cycle delay on enable changes and irregular valid patterns.

// File: rtl/dcblk_pkg.sv
package dcblk_pkg;

    typedef enum logic [0:0] {
        ST_HOLD  = 1'b0,
        ST_TRACK = 1'b1
    } chan_state_e;

    typedef enum logic [0:0] {
        MODE_PIN = 1'b0,
        MODE_REG = 1'b1
    } ctl_mode_e;

endpackage

// File: rtl/dcblk_ctrl.sv
module dcblk_ctrl
    import dcblk_pkg::*;
(
    input  logic sw_mode,
    input  logic pin_en_b,
    input  logic reg_en_a,
    input  logic reg_en_b,
    output logic grp_en_a,
    output logic grp_en_b
);

    ctl_mode_e mode;

    always_comb begin
        mode = ctl_mode_e'(sw_mode);
        grp_en_a = 1'b1;
        grp_en_b = 1'b0;
        unique case (mode)
            MODE_PIN: begin
                grp_en_a = 1'b1;
                grp_en_b = pin_en_b;
            end
            MODE_REG: begin
                grp_en_a = reg_en_a;
                grp_en_b = reg_en_b;
            end
        endcase
    end

endmodule

// File: rtl/dcblk_chan.sv
module dcblk_chan
    import dcblk_pkg::*;
#(
    parameter int DW = 24,
    parameter int K  = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          grp_en,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          tracking
);

    localparam int AW = DW + K + 2;
    localparam logic signed [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

    chan_state_e state_q, state_d;

    logic signed [AW-1:0] acc_q, acc_d, x_ext, err, stp;
    logic signed [DW:0]   x_w, off_w, diff;
    logic signed [DW-1:0] sat_w;
    logic                 ovf;
    logic                 out_valid_q;
    logic [DW-1:0]        out_data_q;

    // next-state logic: FREEZE and RESUME transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  if (grp_en)  state_d = ST_TRACK;
            ST_TRACK: if (!grp_en) state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // leaky integrator datapath
    always_comb begin
        x_ext = $signed({{2{in_data[DW-1]}}, in_data, {K{1'b0}}});
        err   = x_ext - acc_q;
        stp   = err >>> K;
        acc_d = acc_q + stp;
    end

    // subtraction and saturation
    always_comb begin
        x_w   = $signed({in_data[DW-1], in_data});
        off_w = acc_q[K +: DW+1];
        diff  = x_w - off_w;
        ovf   = diff[DW] != diff[DW-1];
        if (ovf) sat_w = diff[DW] ? SMIN : SMAX;
        else     sat_w = diff[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (in_valid && state_q == ST_TRACK) begin
            acc_q <= acc_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_q <= 1'b0;
            out_data_q  <= '0;
        end else begin
            out_valid_q <= in_valid;
            if (in_valid) out_data_q <= sat_w;
        end
    end

    assign out_valid = out_valid_q;
    assign out_data  = out_data_q;
    assign tracking  = (state_q == ST_TRACK);

    AST_HOLD_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> (acc_q == $past(acc_q))); // R5
    AST_IDLE_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid) |=> (acc_q == $past(acc_q))); // R11
    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid) |=> (!out_valid && $stable(out_data))); // R2
    AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ovf) |=> (out_data == ($past(diff[DW]) ? SMIN : SMAX))); // R7

endmodule

// File: rtl/dcblk_top.sv
module dcblk_top
    import dcblk_pkg::*;
#(
    parameter int NCH_A = 4,
    parameter int NCH_B = 2,
    parameter int DW    = 24,
    parameter int K     = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sw_mode,
    input  logic                       pin_en_b,
    input  logic                       reg_en_a,
    input  logic                       reg_en_b,
    input  logic [NCH_A+NCH_B-1:0]     in_valid,
    input  logic [(NCH_A+NCH_B)*DW-1:0] in_data,
    output logic [NCH_A+NCH_B-1:0]     out_valid,
    output logic [(NCH_A+NCH_B)*DW-1:0] out_data
);

    localparam int NCH = NCH_A + NCH_B;

    logic           grp_en_a, grp_en_b;
    logic [NCH-1:0] trk;

    dcblk_ctrl u_ctrl (
        .sw_mode  (sw_mode),
        .pin_en_b (pin_en_b),
        .reg_en_a (reg_en_a),
        .reg_en_b (reg_en_b),
        .grp_en_a (grp_en_a),
        .grp_en_b (grp_en_b)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic en_w;
        if (ch < NCH_A) begin : g_a
            assign en_w = grp_en_a;
        end else begin : g_b
            assign en_w = grp_en_b;
        end
        dcblk_chan #(.DW(DW), .K(K)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .grp_en    (en_w),
            .in_valid  (in_valid[ch]),
            .in_data   (in_data[ch*DW +: DW]),
            .out_valid (out_valid[ch]),
            .out_data  (out_data[ch*DW +: DW]),
            .tracking  (trk[ch])
        );
    end

    AST_PIN_GROUP_A_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_mode) |=> (&trk[NCH_A-1:0])); // R8
    AST_PIN_GROUP_B_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_mode) |=> (trk[NCH-1] == $past(pin_en_b))); // R8
    AST_REG_GROUP_A_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_mode) |=> (trk[0] == $past(reg_en_a))); // R9
    AST_REG_GROUP_B_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_mode) |=> (trk[NCH-1] == $past(reg_en_b))); // R9

endmodule

// File: tb/dcblk_top_test.sv
module dcblk_top_test;

    localparam int  CLK_PERIOD = 10;
    localparam int  NCH = 6;
    localparam int  NA  = 4;
    localparam int  DW  = 24;
    localparam int  K   = 10;
    localparam int  WATCHDOG = 150000;
    localparam longint SMAX = 8388607;
    localparam longint SMIN = -8388608;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_mode = 1'b1, pin_en_b = 1'b0, reg_en_a = 1'b0, reg_en_b = 1'b0;
    logic [NCH-1:0]    in_valid = '0;
    logic [NCH*DW-1:0] in_data = '0;
    logic [NCH-1:0]    out_valid;
    logic [NCH*DW-1:0] out_data;

    int checks = 0;
    int fails  = 0;

    longint xin   [NCH];
    longint acc_m [NCH];
    longint last_m[NCH];
    bit     trk_m [NCH];
    logic [NCH-1:0] vin;

    always #(CLK_PERIOD/2) clk = ~clk;

    dcblk_top uut (
        .clk(clk), .rst_n(rst_n), .sw_mode(sw_mode), .pin_en_b(pin_en_b),
        .reg_en_a(reg_en_a), .reg_en_b(reg_en_b), .in_valid(in_valid),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic longint sat(input longint v);
        if (v > SMAX) return SMAX;
        if (v < SMIN) return SMIN;
        return v;
    endfunction

    function automatic bit en_eff(input int ch);
        if (!sw_mode) return (ch < NA) ? 1'b1 : pin_en_b;
        return (ch < NA) ? reg_en_a : reg_en_b;
    endfunction

    function automatic longint get_out(input int ch);
        logic signed [DW-1:0] s;
        s = out_data[ch*DW +: DW];
        return longint'(s);
    endfunction

    task automatic chk(input string req, input longint act, input longint exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // one sample cycle; called and returns at a falling edge
    task automatic step(input string req);
        for (int ch = 0; ch < NCH; ch++) begin
            logic [63:0] t;
            t = xin[ch];
            in_data[ch*DW +: DW] = t[DW-1:0];
        end
        in_valid = vin;
        for (int ch = 0; ch < NCH; ch++) begin
            if (vin[ch]) begin
                last_m[ch] = sat(xin[ch] - (acc_m[ch] >>> K));
                if (trk_m[ch]) acc_m[ch] = acc_m[ch] + (((xin[ch] <<< K) - acc_m[ch]) >>> K);
            end
        end
        for (int ch = 0; ch < NCH; ch++) trk_m[ch] = en_eff(ch);
        @(posedge clk);
        @(negedge clk);
        for (int ch = 0; ch < NCH; ch++) begin
            chk(req, longint'(out_valid[ch]), longint'(vin[ch]), $sformatf("out_valid ch%0d", ch));
            chk(req, get_out(ch), last_m[ch], $sformatf("out_data ch%0d", ch));
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        longint held [NCH];
        longint sum  [NCH];
        for (int ch = 0; ch < NCH; ch++) begin
            acc_m[ch] = 0; last_m[ch] = 0; trk_m[ch] = 0; xin[ch] = 0;
        end
        vin = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", longint'(out_valid), 0, "out_valid after reset");
        for (int ch = 0; ch < NCH; ch++) chk("R1", get_out(ch), 0, $sformatf("out_data ch%0d after reset", ch));

        // R1: first sample passes through unchanged (state still held, acc zero)
        vin = '1;
        for (int ch = 0; ch < NCH; ch++) xin[ch] = 1000 * (ch + 1) - 3500;
        sw_mode = 1'b1; reg_en_a = 1'b1; reg_en_b = 1'b1;
        step("R1");
        for (int ch = 0; ch < NCH; ch++) chk("R1", get_out(ch), xin[ch], $sformatf("passthrough ch%0d", ch));

        // R3/R4: DC plus square tone, tracking in register mode
        for (int ch = 0; ch < NCH; ch++) sum[ch] = 0;
        for (int n = 0; n < 6000; n++) begin
            for (int ch = 0; ch < NCH; ch++)
                xin[ch] = (ch - 2) * 80000 + (((n % 64) < 32) ? 3000 : -3000);
            step("R3");
            if (n >= 6000 - 64)
                for (int ch = 0; ch < NCH; ch++) sum[ch] += get_out(ch);
        end
        for (int ch = 0; ch < NCH; ch++) begin
            longint m;
            m = sum[ch] / 64;
            chk("R3", (m < 2000 && m > -2000) ? 1 : 0, 1, $sformatf("mean near zero ch%0d mean=%0d", ch, m));
        end

        // R5/R10: freeze; the cycle of the change still tracks
        reg_en_a = 1'b0; reg_en_b = 1'b0;
        step("R10");
        for (int n = 0; n < 200; n++) begin
            for (int ch = 0; ch < NCH; ch++) xin[ch] = (n * 4099 + ch * 777) % 400000 - 200000;
            step("R5");
            for (int ch = 0; ch < NCH; ch++) begin
                if (n == 0) held[ch] = xin[ch] - get_out(ch);
                else chk("R5", xin[ch] - get_out(ch), held[ch], $sformatf("held offset ch%0d", ch));
            end
        end

        // R6/R11: resume with irregular valid pattern
        reg_en_a = 1'b1; reg_en_b = 1'b1;
        for (int n = 0; n < 1500; n++) begin
            for (int ch = 0; ch < NCH; ch++) begin
                vin[ch] = ((n + ch) % 3) != 0;
                xin[ch] = 50000 - ch * 20000 + ((n % 16) * 500);
            end
            step((n % 3) == 0 ? "R11" : "R6");
        end
        vin = '1;

        // R8: pin mode, register bits toggled but ignored
        sw_mode = 1'b0;
        for (int n = 0; n < 2000; n++) begin
            reg_en_a = n[0];
            reg_en_b = n[1];
            pin_en_b = (n / 250) % 2 == 1;
            for (int ch = 0; ch < NCH; ch++) xin[ch] = 120000 - ch * 45000 + ((n % 8) * 900);
            step("R8");
        end

        // R9: register mode, pin toggled but ignored
        sw_mode = 1'b1;
        for (int n = 0; n < 2000; n++) begin
            pin_en_b = n[0];
            reg_en_a = (n / 300) % 2 == 0;
            reg_en_b = (n / 200) % 2 == 1;
            for (int ch = 0; ch < NCH; ch++) xin[ch] = -90000 + ch * 30000 + ((n % 32) * 200);
            step("R9");
        end

        // R7: drive offsets to full scale, freeze, apply opposite extreme
        reg_en_a = 1'b1; reg_en_b = 1'b1;
        for (int n = 0; n < 4000; n++) begin
            for (int ch = 0; ch < NCH; ch++) xin[ch] = (ch < 3) ? SMAX : SMIN;
            step("R7");
        end
        reg_en_a = 1'b0; reg_en_b = 1'b0;
        step("R7");
        for (int n = 0; n < 20; n++) begin
            for (int ch = 0; ch < NCH; ch++) xin[ch] = (ch < 3) ? SMIN : SMAX;
            step("R7");
            for (int ch = 0; ch < NCH; ch++)
                chk("R7", get_out(ch), (ch < 3) ? SMIN : SMAX, $sformatf("clamp ch%0d", ch));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule